// File: doc/BRIEF.md
# I2C High-Speed Mode Tracker

This block watches the clock and data lines of an I2C bus from the target side. A system clock much faster than the bus rate samples both lines. Each line passes through a synchronizer and a glitch filter. From the cleaned lines the block detects START, repeated START and STOP conditions and frames the serial bits into bytes, MSB first. Before a controller may clock the bus at high speed, it must send a special master code. The block recognises that code, switches a mode flag, and keeps the flag until the next STOP.

The mode flag has two uses. It tells neighbouring logic that the bus runs in high-speed operation. It also shortens the glitch filters, so that narrow high-speed clock phases pass while spikes are still rejected. The first byte after any START or repeated START that is not taken as a master code is reported as the control byte. The block drives the acknowledge for the control byte and for write data addressed to it, through an open-drain pull-down request.

Top module: `i2chs_mode_tracker`

## Requirements
- R1: After reset, hs_mode_o, sda_pull_o, master_code_seen_o and ctrl_valid_o are all 0, and the block waits for a START.
- R2: In fast/standard mode, a level change on either line is ignored unless it lasts at least FS_LEN system clocks. A shorter spike on SCL or SDA during a byte does not disturb framing and creates no START or STOP.
- R3: In high-speed mode the filter length is HS_LEN system clocks, so bus phases shorter than FS_LEN but at least HS_LEN are decoded correctly.
- R4: In fast/standard mode, a first byte after a START or repeated START whose bits 7..3 are 00001 is a master code, whatever its bits 2..0. It produces a one-cycle master_code_seen_o pulse and sets hs_mode_o. It produces no ctrl_valid_o pulse.
- R5: A master code is never acknowledged: sda_pull_o stays 0 during its ninth clock.
- R6: A first byte after a START or repeated START that is not a master code produces a one-cycle ctrl_valid_o pulse, with the byte (first bit received in bit 7) on ctrl_byte_o. This holds in either mode.
- R7: A control byte is acknowledged (sda_pull_o high during the ninth clock) exactly when its bits 7..1 equal the ADDR parameter.
- R8: Later bytes are acknowledged only when the preceding control byte matched ADDR and had bit 0 = 0 (write). Otherwise they are not acknowledged.
- R9: A repeated START in high-speed mode leaves hs_mode_o at 1.
- R10: A STOP returns hs_mode_o to 0.
- R11: A byte with the master-code pattern anywhere else (a later byte, or a first byte while already in high-speed mode) is ordinary data. It causes no master_code_seen_o pulse and no change of mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| sda_pull_o | output | 1 | Request to pull the data line low (acknowledge) |
| hs_mode_o | output | 1 | High-speed mode flag |
| master_code_seen_o | output | 1 | One-cycle pulse when a master code is accepted |
| ctrl_valid_o | output | 1 | One-cycle pulse when a control byte is complete |
| ctrl_byte_o | output | 8 | Last control byte received |

## Verification
The mode flag changes the filter length in the same cycle that a byte completes. Because of this, the master-code byte finishes under one filter length and the acknowledge slot and repeated START that follow are filtered with the other. The bench provokes this by keeping fast/standard timing through the master code's ninth clock and the repeated START, then switching to high-speed timing. It judges the result by checking that the master code gets no acknowledge, that no false START or STOP appears, and that the next control byte arrives intact and is acknowledged as its address dictates. Spikes injected while SCL is high check the same cycle-level interplay between filtering and condition detection.

// File: rtl/i2chs_pkg.sv
package i2chs_pkg;

    // Bus events derived from the filtered lines, one system cycle wide.
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_evt_t;

    localparam logic [4:0] MC_PREFIX = 5'b00001;

endpackage

// File: rtl/i2chs_glitch_filter.sv
module i2chs_glitch_filter #(
    parameter int FS_LEN = 12,
    parameter int HS_LEN = 2,
    parameter int SYNC   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_i,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FS_LEN + 1);

    typedef struct packed {
        logic [SYNC-1:0] sync;
        logic [CW-1:0]   cnt;
        logic            filt;
    } flt_state_t;

    flt_state_t st_q, st_d;
    logic [CW-1:0] lim;
    logic          smp;

    assign lim = hs_i ? CW'(HS_LEN - 1) : CW'(FS_LEN - 1);
    assign smp = st_q.sync[SYNC-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC-2:0], raw_i};
        if (smp == st_q.filt) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= lim) begin
            st_d.filt = smp;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= '1;
            st_q.cnt  <= '0;
            st_q.filt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt_o = st_q.filt;

    AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (smp == st_q.filt) |=> $stable(st_q.filt)); // R2

endmodule

// File: rtl/i2chs_cond_detect.sv
module i2chs_cond_detect
    import i2chs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_f_i,
    input  logic     sda_f_i,
    output bus_evt_t evt_o
);
    typedef struct packed {
        logic     scl;
        logic     sda;
        bus_evt_t evt;
    } cd_state_t;

    cd_state_t st_q, st_d;

    always_comb begin
        st_d              = st_q;
        st_d.scl          = scl_f_i;
        st_d.sda          = sda_f_i;
        st_d.evt.start    = st_q.scl & scl_f_i & st_q.sda & ~sda_f_i;
        st_d.evt.stop     = st_q.scl & scl_f_i & ~st_q.sda & sda_f_i;
        st_d.evt.scl_rise = ~st_q.scl & scl_f_i;
        st_d.evt.scl_fall = st_q.scl & ~scl_f_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.scl <= 1'b1;
            st_q.sda <= 1'b1;
            st_q.evt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;

endmodule

// File: rtl/i2chs_byte_framer.sv
module i2chs_byte_framer
    import i2chs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_evt_t   evt_i,
    input  logic       sda_f_i,
    input  logic       ack_en_i,
    output logic       done_o,
    output logic       first_o,
    output logic [7:0] byte_o,
    output logic       sda_pull_o
);
    typedef struct packed {
        logic       busy;
        logic [3:0] bitcnt;
        logic [7:0] shreg;
        logic       first;
        logic       done;
        logic       ack_arm;
        logic       pull;
    } fr_state_t;

    fr_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.done) begin
            st_d.ack_arm = ack_en_i;
        end
        if (evt_i.start) begin
            st_d.busy    = 1'b1;
            st_d.bitcnt  = '0;
            st_d.first   = 1'b1;
            st_d.pull    = 1'b0;
            st_d.ack_arm = 1'b0;
        end else if (evt_i.stop) begin
            st_d.busy    = 1'b0;
            st_d.bitcnt  = '0;
            st_d.pull    = 1'b0;
            st_d.ack_arm = 1'b0;
        end else if (st_q.busy) begin
            if (evt_i.scl_rise) begin
                if (st_q.bitcnt < 4'd8) begin
                    st_d.shreg  = {st_q.shreg[6:0], sda_f_i};
                    st_d.done   = (st_q.bitcnt == 4'd7);
                    st_d.bitcnt = st_q.bitcnt + 4'd1;
                end else if (st_q.bitcnt == 4'd8) begin
                    st_d.bitcnt = 4'd9;
                end
            end
            if (evt_i.scl_fall) begin
                if (st_q.bitcnt == 4'd8) begin
                    st_d.pull = st_q.ack_arm;
                end else if (st_q.bitcnt == 4'd9) begin
                    st_d.pull    = 1'b0;
                    st_d.bitcnt  = '0;
                    st_d.first   = 1'b0;
                    st_d.ack_arm = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o     = st_q.done;
    assign first_o    = st_q.first;
    assign byte_o     = st_q.shreg;
    assign sda_pull_o = st_q.pull;

    AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pull) |-> $past(evt_i.scl_fall)); // R7
    AST_NO_PULL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> !st_q.pull); // R8

endmodule

// File: rtl/i2chs_mode_ctrl.sv
module i2chs_mode_ctrl
    import i2chs_pkg::*;
#(
    parameter logic [6:0] ADDR = 7'h2C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       done_i,
    input  logic       first_i,
    input  logic [7:0] byte_i,
    output logic       ack_en_o,
    output logic       hs_o,
    output logic       mc_seen_o,
    output logic       ctrl_valid_o,
    output logic [7:0] ctrl_byte_o
);
    typedef struct packed {
        logic       hs;
        logic       sel_wr;
        logic       mc;
        logic       cv;
        logic [7:0] ctrl;
    } md_state_t;

    md_state_t st_q, st_d;
    logic      is_mc;
    logic      addr_hit;

    assign is_mc    = (byte_i[7:3] == MC_PREFIX);
    assign addr_hit = (byte_i[7:1] == ADDR);

    always_comb begin
        st_d     = st_q;
        st_d.mc  = 1'b0;
        st_d.cv  = 1'b0;
        ack_en_o = 1'b0;
        if (stop_i) begin
            st_d.hs     = 1'b0;
            st_d.sel_wr = 1'b0;
        end else if (start_i) begin
            st_d.sel_wr = 1'b0;
        end else if (done_i) begin
            if (first_i && !st_q.hs && is_mc) begin
                st_d.hs     = 1'b1;
                st_d.mc     = 1'b1;
                st_d.sel_wr = 1'b0;
            end else if (first_i) begin
                st_d.cv     = 1'b1;
                st_d.ctrl   = byte_i;
                ack_en_o    = addr_hit;
                st_d.sel_wr = addr_hit & ~byte_i[0];
            end else begin
                ack_en_o = st_q.sel_wr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_o         = st_q.hs;
    assign mc_seen_o    = st_q.mc;
    assign ctrl_valid_o = st_q.cv;
    assign ctrl_byte_o  = st_q.ctrl;

    AST_HS_DROP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !st_q.hs); // R10
    AST_HS_HOLD_SR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && st_q.hs) |=> st_q.hs); // R9
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.mc && st_q.cv)); // R4
    AST_MC_ONLY_FS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.mc) |-> $rose(st_q.hs)); // R11

endmodule

// File: rtl/i2chs_mode_tracker.sv
module i2chs_mode_tracker
    import i2chs_pkg::*;
#(
    parameter logic [6:0] ADDR   = 7'h2C,
    parameter int         FS_LEN = 12,
    parameter int         HS_LEN = 2,
    parameter int         SYNC   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic       hs_mode_o,
    output logic       master_code_seen_o,
    output logic       ctrl_valid_o,
    output logic [7:0] ctrl_byte_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] filt_lines;
    logic              hs;
    bus_evt_t          evt;
    logic              done;
    logic              first;
    logic [7:0]        rx_byte;
    logic              ack_en;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2chs_glitch_filter #(
            .FS_LEN(FS_LEN),
            .HS_LEN(HS_LEN),
            .SYNC  (SYNC)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .hs_i  (hs),
            .raw_i (raw_lines[g]),
            .filt_o(filt_lines[g])
        );
    end

    i2chs_cond_detect u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_f_i(filt_lines[0]),
        .sda_f_i(filt_lines[1]),
        .evt_o  (evt)
    );

    i2chs_byte_framer u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .sda_f_i   (filt_lines[1]),
        .ack_en_i  (ack_en),
        .done_o    (done),
        .first_o   (first),
        .byte_o    (rx_byte),
        .sda_pull_o(sda_pull_o)
    );

    i2chs_mode_ctrl #(
        .ADDR(ADDR)
    ) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (evt.start),
        .stop_i      (evt.stop),
        .done_i      (done),
        .first_i     (first),
        .byte_i      (rx_byte),
        .ack_en_o    (ack_en),
        .hs_o        (hs),
        .mc_seen_o   (master_code_seen_o),
        .ctrl_valid_o(ctrl_valid_o),
        .ctrl_byte_o (ctrl_byte_o)
    );

    assign hs_mode_o = hs;

    AST_MC_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        master_code_seen_o |-> !sda_pull_o); // R5

endmodule

// File: tb/i2chs_mode_tracker_tb_top.sv
module i2chs_mode_tracker_tb_top;
    localparam logic [6:0] ADDR = 7'h2C;
    localparam int FS_LEN = 12;
    localparam int HS_LEN = 2;
    localparam int FS_H   = 40;
    localparam int HS_H   = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_bus;
    logic       sda_pull, hs, mc_seen, cv;
    logic [7:0] cbyte;

    assign sda_bus = m_sda & ~sda_pull;

    i2chs_mode_tracker #(.ADDR(ADDR), .FS_LEN(FS_LEN), .HS_LEN(HS_LEN), .SYNC(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .hs_mode_o(hs), .master_code_seen_o(mc_seen),
        .ctrl_valid_o(cv), .ctrl_byte_o(cbyte)
    );

    int checks = 0;
    int errors = 0;
    int n_mc = 0;
    int n_cv = 0;
    logic [7:0] last_cv = 8'h00;
    int half = FS_H;

    always @(negedge clk) begin
        if (rst_n && cv) begin n_cv++; last_cv = cbyte; end
        if (rst_n && mc_seen) n_mc++;
    end

    function automatic logic is_mc(input logic [7:0] b);
        return b[7:3] == 5'b00001;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_c();
        m_sda = 1'b1; idle(half);
        m_scl = 1'b1; idle(half);
        m_sda = 1'b0; idle(half);
        m_scl = 1'b0; idle(half);
    endtask

    task automatic stop_c();
        m_sda = 1'b0; idle(half);
        m_scl = 1'b1; idle(half);
        m_sda = 1'b1; idle(2 * half);
    endtask

    // g: 0 none, 1 spike on SCL, 2 spike on SDA, both during bit 4's high phase
    task automatic send_byte(input logic [7:0] b, input int g, output logic ackd);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; idle(half / 2);
            m_scl = 1'b1;
            if (i == 4 && g != 0) begin
                idle(10);
                if (g == 1) m_scl = 1'b0; else m_sda = ~m_sda;
                idle(FS_LEN - 2);
                if (g == 1) m_scl = 1'b1; else m_sda = b[i];
                idle(half - 10 - (FS_LEN - 2));
            end else begin
                idle(half);
            end
            m_scl = 1'b0; idle(half / 2);
        end
        m_sda = 1'b1; idle(half);
        m_scl = 1'b1; idle(half / 2);
        ackd = ~sda_bus;
        idle(half / 2);
        m_scl = 1'b0; idle(half);
    endtask

    // One transfer: optional master code + repeated START, then control and data bytes.
    task automatic run_txn(input bit use_hs, input logic [7:0] mcb, input logic [7:0] ctl,
                           input int nd, input int g);
        int   mc0, cv0;
        logic a;
        logic exp_data_ack;
        mc0 = n_mc; cv0 = n_cv;
        half = FS_H;
        start_c();
        if (use_hs) begin
            send_byte(mcb, 0, a);
            chk("R5 master code not acked", a, 1'b0);
            chk("R4 master code pulse", n_mc - mc0, 1);
            chk("R4 hs set", hs, 1'b1);
            start_c();
            chk("R9 hs kept over Sr", hs, 1'b1);
            half = HS_H;
        end
        send_byte(ctl, g, a);
        chk(use_hs ? "R3 R6 control pulse" : "R6 control pulse", n_cv - cv0, 1);
        chk("R6 control value", last_cv, ctl);
        chk("R7 control ack", a, ctl[7:1] == ADDR);
        exp_data_ack = (ctl[7:1] == ADDR) && !ctl[0];
        for (int k = 0; k < nd; k++) begin
            send_byte(8'($urandom), 0, a);
            chk("R8 data ack", a, exp_data_ack);
        end
        chk("R11 no extra master code", n_mc - mc0, use_hs ? 1 : 0);
        stop_c();
        chk("R10 hs cleared by stop", hs, 1'b0);
        half = FS_H;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic a;
        int   mc0, cv0;
        logic [6:0] ad;
        void'($urandom(32'h5EED));
        idle(5);
        rst_n = 1'b1;
        idle(30);
        // R1 reset state
        chk("R1 hs", hs, 1'b0);
        chk("R1 pull", sda_pull, 1'b0);
        chk("R1 mc pulse", n_mc, 0);
        chk("R1 ctrl pulse", n_cv, 0);

        // Plain fast/standard write and a read
        run_txn(1'b0, 8'h00, {ADDR, 1'b0}, 2, 0);
        run_txn(1'b0, 8'h00, {ADDR, 1'b1}, 1, 0);
        // High-speed entry, master code low bits vary (R4)
        run_txn(1'b1, 8'h0D, {ADDR, 1'b0}, 3, 0);
        run_txn(1'b1, 8'h08, {ADDR, 1'b0}, 1, 0);
        run_txn(1'b1, 8'h0F, {7'h51, 1'b0}, 1, 0);

        // R9: Sr at high speed to another target, then to this target
        mc0 = n_mc; cv0 = n_cv;
        half = FS_H; start_c();
        send_byte(8'h0A, 0, a);
        chk("R5 master code not acked", a, 1'b0);
        start_c(); half = HS_H;
        send_byte({7'h33, 1'b0}, 0, a);
        chk("R7 other target not acked", a, 1'b0);
        send_byte(8'hA5, 0, a);
        chk("R8 data to other target not acked", a, 1'b0);
        start_c();
        chk("R9 hs kept after second Sr", hs, 1'b1);
        send_byte({ADDR, 1'b0}, 0, a);
        chk("R7 own address acked at high speed", a, 1'b1);
        // R11: master-code pattern as first byte while already high speed
        start_c();
        send_byte(8'h09, 0, a);
        chk("R11 pattern is control byte in hs", last_cv, 8'h09);
        chk("R11 no master code in hs", n_mc - mc0, 1);
        chk("R11 control pulses", n_cv - cv0, 3);
        chk("R11 hs unchanged", hs, 1'b1);
        stop_c();
        chk("R10 hs cleared", hs, 1'b0);
        half = FS_H;

        // R11: pattern as a data byte in fast/standard mode
        mc0 = n_mc;
        start_c();
        send_byte({ADDR, 1'b0}, 0, a);
        send_byte(8'h0B, 0, a);
        chk("R11 pattern data acked as data", a, 1'b1);
        chk("R11 no master code for data", n_mc - mc0, 0);
        chk("R11 mode unchanged", hs, 1'b0);
        stop_c();

        // R2: spikes shorter than FS_LEN on SCL and on SDA
        run_txn(1'b0, 8'h00, {ADDR, 1'b0}, 1, 1);
        run_txn(1'b0, 8'h00, {ADDR, 1'b0}, 1, 2);
        chk("R2 mode unaffected by spikes", hs, 1'b0);

        // Random transfers
        for (int t = 0; t < 14; t++) begin
            ad = ($urandom_range(0, 1) == 1) ? ADDR : 7'($urandom_range(16, 127));
            run_txn(1'($urandom_range(0, 1)), {5'b00001, 3'($urandom)},
                    {ad, 1'($urandom)}, $urandom_range(0, 2), 0);
        end

        summary();
        $finish;
    end
endmodule